// File: doc/BRIEF.md
# Fractional M/N clock divider

This block produces a train of single-cycle enable pulses on one system clock. Over time, the pulses arrive at the selected source's strobe rate multiplied by M and divided by N. Four source strobes enter as clock-enable qualifiers. A two-bit select field picks one of them. Code 2 is reserved and selects nothing.

A single 32-bit control word sets the configuration. It holds the source select, a gate bit and the M and N ratio terms. Reading the port returns the configuration currently in use.

Each qualified strobe adds M to an accumulator. When the accumulator reaches N or more, N is subtracted and one pulse is emitted. A write whose ratio terms break the range rules is rejected and raises a sticky error flag. A ratio write that is accepted waits until no output pulse is in flight. It then loads and starts again from a cleared accumulator.

Top module: `rate_gen`

## Requirements
- R1: With the accumulator cleared and T qualified strobes, the block emits exactly floor(T*M/N) pulses. Each pulse is one clock wide and appears on the clock after the strobe that completes it.
- R2: The control word has these fields: N in bits 12:0, M in bits 21:13, the gate in bit 29 and the source select in bits 31:30. All other bits read as zero. A read returns the select, the gate and the M and N values in use.
- R3: Two consecutive clocks never both carry an output pulse, because N is at least twice M.
- R4: While the gate bit (bit 29) reads 0, no pulse is emitted and strobes are ignored. A read returns the gate's current value.
- R5: Only strobes on the source whose index equals the select field count. Strobes on other sources have no effect.
- R6: While the select field holds code 2, no pulse is emitted, even when source 2 strobes.
- R7: A write is rejected when M is 0, when N is below 2, or when N is below 2*M. A rejected write sets the error flag, which stays set until reset, and the M and N values in use stay unchanged. The select and gate fields of the write still take effect.
- R8: The boundary pairs M=511, N=1022 and M=1, N=8191 are accepted without raising the error flag.
- R9: An accepted ratio loads only in a clock with no output pulse. The accumulator is cleared to zero when the ratio loads.
- R10: After reset the control word reads 0x00002002: source 0, gate off, M=1, N=2. The error flag and the output are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Enable strobes of the four sources |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word in use |
| pulse_out | output | 1 | Rate-divided enable pulse |
| cfg_err | output | 1 | Sticky rejected-write flag |

## Verification
The assertions check the following on every cycle:
- pulses are never back to back;
- no pulse follows a closed gate or the reserved select;
- a rejected write sets the sticky flag and leaves M and N as read;
- a pending ratio is held while a pulse is out.

Only the bench scenarios can show the long-run pulse count for a given ratio, and that the accumulator is cleared when a new ratio loads. They also show that unselected sources are ignored and that the boundary ratios are accepted.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 13;
  localparam int SEL_W   = 2;
  localparam int NUM_SRC = 1 << SEL_W;
  localparam int WORD_W  = 32;
  localparam int N_LSB   = 0;
  localparam int M_LSB   = N_LSB + N_W;
  localparam int EN_BIT  = 29;
  localparam int SEL_LSB = 30;
  localparam logic [SEL_W-1:0] SEL_RSV = 2'd2;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             en;
    logic [M_W-1:0]   m;
    logic [N_W-1:0]   n;
  } cfg_t;

  function automatic cfg_t unpack_word(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.sel = w[SEL_LSB +: SEL_W];
    c.en  = w[EN_BIT];
    c.m   = w[M_LSB +: M_W];
    c.n   = w[N_LSB +: N_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[EN_BIT]           = c.en;
    w[M_LSB +: M_W]     = c.m;
    w[N_LSB +: N_W]     = c.n;
    return w;
  endfunction

  function automatic logic ratio_ok(input logic [M_W-1:0] m, input logic [N_W-1:0] n);
    logic [N_W:0] twice_m;
    twice_m = (N_W+1)'(m) << 1;
    return (m != '0) && (n >= N_W'(2)) && ({1'b0, n} >= twice_m);
  endfunction
endpackage

// File: rtl/rg_cfg_regs.sv
module rg_cfg_regs
  import rate_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pulse_busy,
  output cfg_t              active,
  output logic              pend,
  output logic              apply,
  output logic              err
);
  cfg_t           wr_cfg;
  logic           wr_ok;
  logic [M_W-1:0] pend_m;
  logic [N_W-1:0] pend_n;

  assign wr_cfg = unpack_word(wr_data);
  assign wr_ok  = ratio_ok(wr_cfg.m, wr_cfg.n);
  assign apply  = pend && !pulse_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active.sel <= '0;
      active.en  <= 1'b0;
      active.m   <= M_W'(1);
      active.n   <= N_W'(2);
      pend       <= 1'b0;
      pend_m     <= '0;
      pend_n     <= '0;
      err        <= 1'b0;
    end else begin
      if (apply) begin
        active.m <= pend_m;
        active.n <= pend_n;
        pend     <= 1'b0;
      end
      if (wr_en) begin
        active.sel <= wr_cfg.sel;
        active.en  <= wr_cfg.en;
        if (wr_ok) begin
          pend   <= 1'b1;
          pend_m <= wr_cfg.m;
          pend_n <= wr_cfg.n;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rg_src_mux.sv
module rg_src_mux
  import rate_gen_pkg::*;
(
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  input  logic               en,
  output logic               tick
);
  logic [NUM_SRC-1:0] qual;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (SEL_W'(i) == SEL_RSV) begin : g_rsv
      assign qual[i] = 1'b0;
    end else begin : g_use
      assign qual[i] = src_tick[i] && (sel == SEL_W'(i));
    end
  end

  assign tick = en && (|qual);
endmodule

// File: rtl/rg_accum.sv
module rg_accum
  import rate_gen_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           clear,
  input  logic [M_W-1:0] m,
  input  logic [N_W-1:0] n,
  output logic           pulse
);
  logic [N_W-1:0] acc;
  logic [N_W:0]   sum;
  logic           wrap;

  assign sum  = {1'b0, acc} + (N_W+1)'(m);
  assign wrap = sum >= {1'b0, n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      pulse <= 1'b0;
    end else if (clear) begin
      acc   <= '0;
      pulse <= 1'b0;
    end else if (tick) begin
      acc   <= wrap ? N_W'(sum - {1'b0, n}) : N_W'(sum);
      pulse <= wrap;
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/rate_gen.sv
module rate_gen
  import rate_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  src_tick,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pulse_out,
  output logic        cfg_err
);
  cfg_t active;
  logic cfg_pend;
  logic cfg_apply;
  logic src_hit;

  rg_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pulse_busy(pulse_out), .active(active), .pend(cfg_pend),
    .apply(cfg_apply), .err(cfg_err)
  );

  rg_src_mux u_mux (
    .src_tick(src_tick), .sel(active.sel), .en(active.en), .tick(src_hit)
  );

  rg_accum u_acc (
    .clk(clk), .rst_n(rst_n), .tick(src_hit), .clear(cfg_apply),
    .m(active.m), .n(active.n), .pulse(pulse_out)
  );

  assign rd_data = pack_word(active);
endmodule

// File: rtl/rate_gen_chk.sv
module rate_gen_chk
  import rate_gen_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        pulse_out,
  input logic        cfg_err,
  input logic        pend
);
  logic wr_bad;
  assign wr_bad = wr_en && !ratio_ok(wr_data[M_LSB +: M_W], wr_data[N_LSB +: N_W]);

  // R3
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |=> !pulse_out);

  // R4
  gate_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[EN_BIT] |=> !pulse_out);

  // R6
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[SEL_LSB +: SEL_W] == SEL_RSV) |=> !pulse_out);

  // R7
  bad_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> cfg_err);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R7
  bad_write_keeps_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bad && !pend) |=> $stable(rd_data[21:0]));

  // R9
  load_waits_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && pulse_out) |=> $stable(rd_data[21:0]));
endmodule

bind rate_gen rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pulse_out(pulse_out), .cfg_err(cfg_err), .pend(cfg_pend)
);

// File: tb/tb_rate_gen.sv
`timescale 1ns/1ps
module tb_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pulse_out;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  int pcnt = 0;

  rate_gen dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pulse_out(pulse_out), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (pulse_out) pcnt++;

  function automatic logic [31:0] mk(input int sel, input int en, input int m, input int n);
    return (32'(sel & 3) << 30) | (32'(en & 1) << 29) | (32'(m & 511) << 13) | 32'(n & 8191);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    src_tick = '0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write(input logic [31:0] w);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input logic [3:0] mask, input int t, output int got);
    int start;
    start = pcnt;
    src_tick = mask;
    repeat (t) @(negedge clk);
    src_tick = '0;
    repeat (3) @(negedge clk);
    got = pcnt - start;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 reset word", rd_data, 32'h0000_2002);
    check("R10 reset err", 32'(cfg_err), 32'd0);
    check("R10 reset pulse", 32'(pulse_out), 32'd0);
  endtask

  task automatic t_rates();
    int got;
    write(mk(0, 1, 1, 2));
    check("R2 readback", rd_data, mk(0, 1, 1, 2));
    run(4'b0001, 20, got);
    check("R1 M=1 N=2", 32'(got), 32'd10);
    write(mk(1, 1, 3, 7));
    run(4'b0010, 70, got);
    check("R1 M=3 N=7", 32'(got), 32'd30);
    write(mk(3, 1, 5, 13));
    check("R2 readback sel3", rd_data, mk(3, 1, 5, 13));
    run(4'b1000, 26, got);
    check("R1 M=5 N=13", 32'(got), 32'd10);
  endtask

  task automatic t_select();
    int got;
    write(mk(1, 1, 1, 2));
    run(4'b1101, 20, got);
    check("R5 other sources ignored", 32'(got), 32'd0);
    run(4'b1111, 20, got);
    check("R5 selected source counts", 32'(got), 32'd10);
  endtask

  task automatic t_gate();
    int got;
    write(mk(0, 0, 1, 2));
    check("R4 gate reads 0", 32'(rd_data[29]), 32'd0);
    run(4'b1111, 20, got);
    check("R4 gate off no pulses", 32'(got), 32'd0);
    write(mk(0, 1, 1, 2));
    check("R4 gate reads 1", 32'(rd_data[29]), 32'd1);
  endtask

  task automatic t_reserved();
    int got;
    write(mk(2, 1, 1, 2));
    run(4'b1111, 20, got);
    check("R6 reserved select", 32'(got), 32'd0);
    write(mk(0, 1, 1, 2));
    run(4'b0001, 4, got);
    check("R6 valid select resumes", 32'(got), 32'd2);
  endtask

  task automatic t_boundary();
    int got;
    write(mk(0, 1, 511, 1022));
    check("R8 M=511 N=1022 read", rd_data, mk(0, 1, 511, 1022));
    check("R8 M=511 no err", 32'(cfg_err), 32'd0);
    run(4'b0001, 10, got);
    check("R8 M=511 N=1022 rate", 32'(got), 32'd5);
    write(mk(0, 1, 1, 8191));
    check("R8 N=8191 read", rd_data, mk(0, 1, 1, 8191));
    check("R8 N=8191 no err", 32'(cfg_err), 32'd0);
  endtask

  task automatic t_invalid();
    write(mk(0, 1, 3, 7));
    write(mk(1, 1, 0, 7));
    check("R7 M=0 err", 32'(cfg_err), 32'd1);
    check("R7 M=0 ratio kept", rd_data, mk(1, 1, 3, 7));
    write(mk(0, 1, 3, 1));
    check("R7 N=1 ratio kept", rd_data, mk(0, 1, 3, 7));
    write(mk(0, 0, 5, 9));
    check("R7 N<2M ratio kept", rd_data, mk(0, 0, 3, 7));
    write(mk(0, 1, 2, 9));
    check("R7 valid after err applied", rd_data, mk(0, 1, 2, 9));
    check("R7 err sticky", 32'(cfg_err), 32'd1);
    do_reset();
    check("R10 reset clears err", 32'(cfg_err), 32'd0);
  endtask

  task automatic t_reload();
    int got;
    write(mk(0, 1, 1, 3));
    run(4'b0001, 2, got);
    check("R9 partial sum", 32'(got), 32'd0);
    write(mk(0, 1, 1, 3));
    run(4'b0001, 1, got);
    check("R9 accumulator cleared", 32'(got), 32'd0);
    run(4'b0001, 2, got);
    check("R9 count after clear", 32'(got), 32'd1);
  endtask

  initial begin
    t_reset();
    t_rates();
    t_select();
    t_gate();
    t_reserved();
    t_boundary();
    t_invalid();
    t_reload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule